// File: doc/BRIEF.md
# Infrared Pulse Timing Capture Receiver

The receiver watches a single demodulated remote-control line, from an infrared or radio front end, and times its pulses. A programmable prescaler slows the system clock to a sampling tick of nominally 10 MHz. Every duration is counted in these ticks. For each symbol the block records two numbers: how long the carrier was present (the mark) and the full period from the start of that mark to the start of the next one. Software gets the space by subtracting the first from the second. When the line stays quiet for longer than a programmable limit, the train is closed with an all-ones period value. This lets software see where a burst ends.

Captured pairs wait in an eight-entry queue until software reads them through a small word-addressed register port. That port also holds the capture enable, the input polarity control, the timeout limit, the prescaler divisor, and a four-source sticky interrupt set with a write-ones-to-clear register. The interrupt line is the OR of every status bit that is enabled.

Register word addresses on `reg_addr`:

| Addr | Access | Contents |
|------|--------|----------|
| 0x0 | RO | head mark |
| 0x1 | RO | head period; reading it pops the entry |
| 0x2 | RW | interrupt enable |
| 0x3 | RO | interrupt status |
| 0x4 | RW | capture enable |
| 0x5 | RW | timeout limit |
| 0x6 | WO | status clear |
| 0x7 | RO | receive status |
| 0x8 | RW | polarity invert |
| 0x9 | RW | prescaler divisor |

Top module: `irpulse_rx`

## Requirements
- R1: The divisor register (address 0x9, bits 7:0, reset value 20) sets the sampling tick to one tick every divisor system clocks. A value of 0 acts as 1. All durations are counted in ticks.
- R2: Each queue entry holds a mark and a period. The mark is the number of ticks on which the line was seen as carrier-present. The period is the number of ticks from the first carrier tick of that mark up to, but not including, the first carrier tick of the next mark.
- R3: In the space after a mark, a tick with no carrier while the period count is already at or above the timeout limit closes the entry. The closed entry carries that mark and a period of 0xFFFF, and capture then waits for a new mark. The timeout limit sits at address 0x5, bits 15:0, and resets to 0x5000.
- R4: With bit 0 of the polarity register (address 0x8, reset 0) set to 1, a low input counts as carrier present. With it at 0, a high input counts as carrier present.
- R5: Capture runs only while bit 0 of address 0x4 (reset 0) is 1. While it is 0, nothing is queued. Any partly measured symbol is discarded, and the next capture starts at a fresh mark.
- R6: The queue holds 8 entries in arrival order. Reading address 0x0 returns the head mark in bits 15:0 and does not remove it. Reading address 0x1 returns the head period in bits 15:0 and removes the entry. Both read as 0 when the queue is empty.
- R7: An entry that arrives while the queue is full is dropped. The stored entries are left unchanged, and status bit 2 (overrun) is set.
- R8: The interrupt status register (address 0x3) holds four sticky bits. Bit 0 sets when an entry is stored. Bit 1 sets when a timeout entry is stored. Bit 2 sets on overrun. Bit 3 sets while the queue is full. Writing a 1 to a bit position of address 0x6 clears that bit. Bits written as 0 are left alone.
- R9: Output `irq` is high exactly when some interrupt status bit is 1 and the same bit of the enable register (address 0x2, bits 3:0, reset 0) is 1.
- R10: The receive status register (address 0x7) reports the queue occupancy in bits 15:8, which is nonzero exactly when the queue is not empty. It reports the overrun status bit in bit 2. All other bits read 0.
- R11: Mark and period counters saturate at 0xFFFF instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | Demodulated receiver line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 0x1) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the read |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives pulse trains whose lengths are whole multiples of the tick period. This makes each expected count independent of sampling phase, and it repeats the same train with the polarity inverted. A design that counted the space rather than the whole period, or miscounted ticks by one, would return periods that differ from mark plus space. The bench also pushes ten entries into the eight-deep queue and expects the first eight to survive untouched, with overrun and full set and the last-symbol bit left clear; a design that overwrote the head or flagged a dropped timeout would fail there. It also disables capture in the middle of a space, holds a mark longer than 65535 ticks, and pulses interrupt clears. These catch a stale partial entry, a wrapped counter, and a status bit that clears more than asked.

// File: rtl/irpulse_pkg.sv
// Package for the pulse timing receiver. Holds shared widths, the
// register word addresses, the capture state type and a saturating
// increment helper.
package irpulse_pkg;

    localparam int CNT_W = 16;           // width of mark and period counts
    localparam int REG_W = 32;           // register data width
    localparam int ADR_W = 4;            // register word address width

    localparam logic [ADR_W-1:0] A_MARK   = 4'h0;
    localparam logic [ADR_W-1:0] A_PERIOD = 4'h1;
    localparam logic [ADR_W-1:0] A_IEN    = 4'h2;
    localparam logic [ADR_W-1:0] A_ISTAT  = 4'h3;
    localparam logic [ADR_W-1:0] A_ENABLE = 4'h4;
    localparam logic [ADR_W-1:0] A_LIMIT  = 4'h5;
    localparam logic [ADR_W-1:0] A_ICLR   = 4'h6;
    localparam logic [ADR_W-1:0] A_RXSTAT = 4'h7;
    localparam logic [ADR_W-1:0] A_POLINV = 4'h8;
    localparam logic [ADR_W-1:0] A_DIV    = 4'h9;

    typedef enum logic [1:0] {
        CAP_WAIT  = 2'd0,   // no symbol open, waiting for carrier
        CAP_MARK  = 2'd1,   // carrier present, counting mark and period
        CAP_SPACE = 2'd2    // carrier gone, counting period only
    } cap_state_e;

    // Add one, holding at the all-ones value.
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/irpulse_tick.sv
// Sampling prescaler: produces a single-cycle tick once every div_i
// system clocks. Assumes div_i may change at any time; a value of 0
// is treated as 1 and a shrinking divisor wraps at once.
module irpulse_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Effective divisor with zero folded onto one.
    always_comb begin
        lim    = (div_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_i;
        tick_o = (cnt_q >= lim - 1'b1);
    end

    // Count system clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R1: with a steady divisor above one, two ticks never touch.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i > 1 && $stable(div_i)) |=> !tick_o);

endmodule

// File: rtl/irpulse_measure.sv
// Symbol measurement: synchronises the raw line through two flops,
// applies the polarity control, and on each sampling tick advances a
// small state machine that times mark and period. It emits one
// registered push per closed symbol. Assumes tick_i is a one-cycle
// strobe and that enable_i may drop at any time.
module irpulse_measure
    import irpulse_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             invert_i,
    input  logic             rx_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             push_o,
    output logic             last_o,
    output logic [CNT_W-1:0] mark_o,
    output logic [CNT_W-1:0] period_o
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ENDM = {CNT_W{1'b1}};

    logic [1:0]       sync_q;
    logic             carrier;
    cap_state_e       state_q;
    logic [CNT_W-1:0] mark_q;
    logic [CNT_W-1:0] per_q;

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= 2'b00;
        else
            sync_q <= {sync_q[0], rx_i};
    end

    // Carrier-present after the polarity control.
    always_comb carrier = sync_q[1] ^ invert_i;

    // Tick-driven capture state machine with registered push outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CAP_WAIT;
            mark_q   <= '0;
            per_q    <= '0;
            push_o   <= 1'b0;
            last_o   <= 1'b0;
            mark_o   <= '0;
            period_o <= '0;
        end else begin
            push_o <= 1'b0;
            last_o <= 1'b0;
            if (!enable_i) begin
                state_q <= CAP_WAIT;
                mark_q  <= '0;
                per_q   <= '0;
            end else if (tick_i) begin
                case (state_q)
                    CAP_WAIT: begin
                        if (carrier) begin
                            state_q <= CAP_MARK;
                            mark_q  <= ONE;
                            per_q   <= ONE;
                        end
                    end
                    CAP_MARK: begin
                        per_q <= sat_inc(per_q);
                        if (carrier)
                            mark_q <= sat_inc(mark_q);
                        else
                            state_q <= CAP_SPACE;
                    end
                    CAP_SPACE: begin
                        if (carrier) begin
                            push_o   <= 1'b1;
                            mark_o   <= mark_q;
                            period_o <= per_q;
                            state_q  <= CAP_MARK;
                            mark_q   <= ONE;
                            per_q    <= ONE;
                        end else if (per_q >= limit_i) begin
                            push_o   <= 1'b1;
                            last_o   <= 1'b1;
                            mark_o   <= mark_q;
                            period_o <= ENDM;
                            state_q  <= CAP_WAIT;
                        end else begin
                            per_q <= sat_inc(per_q);
                        end
                    end
                    default: state_q <= CAP_WAIT;
                endcase
            end
        end
    end

    // R1: a symbol closes only on a sampling tick.
    assert_push_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(tick_i));

    // R3: a timeout entry returns capture to waiting for a mark.
    assert_timeout_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && last_o) |-> (state_q == CAP_WAIT));

    // R5: nothing is pushed after a cycle with capture disabled.
    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !push_o);

    // R11: a running mark never exceeds the period it belongs to.
    assert_mark_within_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CAP_WAIT) |-> (mark_q <= per_q));

endmodule

// File: rtl/irpulse_fifo.sv
// Capture queue: DEPTH entries of WIDTH bits in arrival order. A push
// while full is dropped and reported on drop_o. A pop on an empty
// queue is ignored. Assumes DEPTH is a power of two.
module irpulse_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic [OCC_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             accept_o,
    output logic             drop_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic             do_pop;

    // Flags and handshake decode.
    always_comb begin
        full_o   = (count_o == OCC_W'(DEPTH));
        empty_o  = (count_o == '0);
        accept_o = push_i && !full_o;
        drop_o   = push_i && full_o;
        do_pop   = pop_i && !empty_o;
        head_o   = empty_o ? '0 : mem_q[rd_q];
    end

    // Entry storage, written only on an accepted push.
    always_ff @(posedge clk) begin
        if (accept_o)
            mem_q[wr_q] <= data_i;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_o <= '0;
        end else begin
            if (accept_o) wr_q <= wr_q + 1'b1;
            if (do_pop)   rd_q <= rd_q + 1'b1;
            case ({accept_o, do_pop})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    // R6: occupancy stays within the queue depth.
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= OCC_W'(DEPTH));

    // R7: a dropped push leaves occupancy alone when nothing is popped.
    assert_drop_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o && !pop_i) |=> (count_o == $past(count_o)));

endmodule

// File: rtl/irpulse_rx.sv
// Pulse timing receiver top: register port, sticky interrupt status,
// and wiring of prescaler, measurement and capture queue. Assumes a
// single-cycle read strobe per access; reading the period address
// pops the queue in the cycle of the strobe.
module irpulse_rx
    import irpulse_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int DIV_W       = 8,
    parameter int DIV_RESET   = 20,
    parameter int LIMIT_RESET = 'h5000,
    localparam int OCC_W      = $clog2(DEPTH) + 1,
    localparam int NSRC       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [ADR_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);

    logic             enable_q;
    logic             invert_q;
    logic [NSRC-1:0]  ien_q;
    logic [NSRC-1:0]  stat_q;
    logic [CNT_W-1:0] limit_q;
    logic [DIV_W-1:0] div_q;

    logic             tick;
    logic             cap_push;
    logic             cap_last;
    logic [CNT_W-1:0] cap_mark;
    logic [CNT_W-1:0] cap_period;

    logic [2*CNT_W-1:0] head;
    logic [OCC_W-1:0]   occ;
    logic               q_full;
    logic               q_empty;
    logic               q_accept;
    logic               q_drop;
    logic               pop;

    logic [NSRC-1:0]  stat_set;
    logic [NSRC-1:0]  stat_clr;

    irpulse_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_q),
        .tick_o (tick)
    );

    irpulse_measure u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .enable_i (enable_q),
        .invert_i (invert_q),
        .rx_i     (rx_in),
        .limit_i  (limit_q),
        .push_o   (cap_push),
        .last_o   (cap_last),
        .mark_o   (cap_mark),
        .period_o (cap_period)
    );

    irpulse_fifo #(.DEPTH(DEPTH), .WIDTH(2*CNT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (cap_push),
        .data_i   ({cap_mark, cap_period}),
        .pop_i    (pop),
        .head_o   (head),
        .count_o  (occ),
        .full_o   (q_full),
        .empty_o  (q_empty),
        .accept_o (q_accept),
        .drop_o   (q_drop)
    );

    // Pop decode and status set/clear vectors.
    always_comb begin
        pop      = reg_rd && (reg_addr == A_PERIOD);
        stat_set = {q_full, q_drop, q_accept && cap_last, q_accept};
        stat_clr = (reg_wr && reg_addr == A_ICLR) ? reg_wdata[NSRC-1:0] : '0;
    end

    // Control registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            invert_q <= 1'b0;
            ien_q    <= '0;
            limit_q  <= CNT_W'(LIMIT_RESET);
            div_q    <= DIV_W'(DIV_RESET);
        end else if (reg_wr) begin
            case (reg_addr)
                A_ENABLE: enable_q <= reg_wdata[0];
                A_POLINV: invert_q <= reg_wdata[0];
                A_IEN:    ien_q    <= reg_wdata[NSRC-1:0];
                A_LIMIT:  limit_q  <= reg_wdata[CNT_W-1:0];
                A_DIV:    div_q    <= reg_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sticky status: new events win over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    // Interrupt line from enabled status.
    always_comb irq = |(stat_q & ien_q);

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MARK:   reg_rdata[CNT_W-1:0] = head[2*CNT_W-1:CNT_W];
            A_PERIOD: reg_rdata[CNT_W-1:0] = head[CNT_W-1:0];
            A_IEN:    reg_rdata[NSRC-1:0]  = ien_q;
            A_ISTAT:  reg_rdata[NSRC-1:0]  = stat_q;
            A_ENABLE: reg_rdata[0]         = enable_q;
            A_LIMIT:  reg_rdata[CNT_W-1:0] = limit_q;
            A_RXSTAT: begin
                reg_rdata[8 +: OCC_W] = occ;
                reg_rdata[2]          = stat_q[2];
            end
            A_POLINV: reg_rdata[0]         = invert_q;
            A_DIV:    reg_rdata[DIV_W-1:0] = div_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R7: the overrun bit only rises after a dropped entry.
    assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[2]) |-> $past(q_drop));

    // R8: a data-available bit stays set unless its clear bit is written.
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !(reg_wr && reg_addr == A_ICLR && reg_wdata[0])) |=> stat_q[0]);

    // R3: the last-symbol bit only rises after a stored timeout entry.
    assert_last_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[1]) |-> $past(cap_push && cap_last && !q_full));

    // R10: a queue that is not empty has raised data-available since the last clear.
    assert_occ_implies_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(!q_empty) |-> stat_q[0]);

endmodule

// File: tb/irpulse_rx_test.sv
`timescale 1ns/1ps
module irpulse_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int cur_div = 20;
    bit pol = 1'b0;

    localparam int NROW = 5;
    localparam int TMARK  [NROW] = '{3, 1, 10, 4, 7};
    localparam int TSPACE [NROW] = '{5, 1, 2, 12, 7};

    irpulse_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Hold carrier (act=1) or no carrier for a whole number of ticks.
    task automatic drive(input bit act, input int ticks);
        rx_in = act ^ pol;
        repeat (ticks * cur_div) @(negedge clk);
    endtask

    task automatic expect_entry(input string tag, input int m, input int p);
        logic [31:0] v;
        rd(4'h0, v); check({tag, " mark"}, v, m);
        rd(4'h1, v); check({tag, " period"}, v, p);
    endtask

    logic [31:0] v;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        rd(4'h5, v); check("R3 limit reset", v, 32'h5000);
        rd(4'h9, v); check("R1 divisor reset", v, 20);
        rd(4'h3, v); check("R8 status reset", v, 0);
        rd(4'h7, v); check("R10 rxstat reset", v, 0);
        check("R9 irq reset", irq, 0);
        rd(4'h1, v); check("R6 empty read", v, 0);

        wr(4'h9, 4); cur_div = 4;
        wr(4'h5, 40);

        // Table walk, plain then inverted polarity.
        for (int pass = 0; pass < 2; pass++) begin
            wr(4'h4, 0);
            pol = pass[0];
            wr(4'h8, pass);
            rx_in = pol;
            repeat (10) @(negedge clk);
            wr(4'h4, 1);
            repeat (10) @(negedge clk);
            for (int i = 0; i < NROW; i++) begin
                drive(1, TMARK[i]);
                drive(0, TSPACE[i]);
            end
            drive(1, 5);
            drive(0, 60);
            rd(4'h3, v); check(pass ? "R4 R8 status" : "R8 status", v, 32'h3);
            rd(4'h7, v); check("R10 occupancy", v, 32'h0600);
            for (int i = 0; i < NROW; i++)
                expect_entry(pass ? "R4 R2 entry" : "R2 entry", TMARK[i], TMARK[i] + TSPACE[i]);
            expect_entry("R3 timeout entry", 5, 32'hFFFF);
            wr(4'h6, 32'hF);
            rd(4'h3, v); check("R8 cleared", v, 0);
        end

        // Interrupt masking and partial clear.
        wr(4'h2, 32'h2);
        drive(1, 2); drive(0, 3); drive(1, 4); drive(0, 60);
        check("R9 irq on last symbol", irq, 1);
        wr(4'h6, 32'h2);
        check("R9 irq after clear", irq, 0);
        rd(4'h3, v); check("R8 partial clear", v, 32'h1);
        expect_entry("R2 irq train", 2, 5);
        expect_entry("R3 irq train", 4, 32'hFFFF);
        wr(4'h2, 0);

        // Disable mid-space discards the partial symbol.
        drive(1, 3); drive(0, 2);
        wr(4'h4, 0);
        drive(1, 4); drive(0, 4);
        rd(4'h7, v); check("R5 nothing while disabled", v, 0);
        wr(4'h4, 1);
        drive(1, 2); drive(0, 3); drive(1, 4); drive(0, 60);
        expect_entry("R5 fresh head", 2, 5);
        expect_entry("R5 second", 4, 32'hFFFF);

        // Overrun: ten pushes into eight places.
        wr(4'h6, 32'hF);
        for (int i = 0; i < 10; i++) begin
            drive(1, 2); drive(0, 2);
        end
        drive(0, 60);
        rd(4'h3, v); check("R7 R8 status after overrun", v, 32'hD);
        rd(4'h7, v); check("R10 full with overflow", v, 32'h0804);
        for (int i = 0; i < 8; i++)
            expect_entry("R7 kept entry", 2, 4);
        rd(4'h7, v); check("R10 drained overflow", v, 32'h0004);
        wr(4'h6, 32'hF);
        rd(4'h7, v); check("R10 cleared", v, 0);

        // Saturation with one tick per clock.
        wr(4'h9, 1); cur_div = 1;
        drive(1, 66000); drive(0, 20);
        expect_entry("R11 saturated", 32'hFFFF, 32'hFFFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule